// File: doc/BRIEF.md
# Debug Register Scan Chain Port

This block is a target-side test data register that lets an external tester reach a small bank of 32-bit debug registers (watchpoint values, masks, controls, a debug status word) through the usual TAP data-register path. The tester first points the scan-chain selector at this chain. It then runs DR scans of 38 bits. Each scan carries a data word, a register address and a direction bit. The frame is decoded when the TAP passes through Update-DR.

A write frame stores its data into the addressed register. A read frame does not return data in the same scan. It latches the addressed register into a holding word. The next Capture-DR moves that word into the data field of the chain, and the following shift sends it out on TDO, bit 0 first. A tester that polls a status word, for example waiting for bits 0 and 3 (mask 0x9) to rise, therefore issues a read and collects the value on the scan after it.

The TAP controller is outside the block. It supplies one-cycle capture, shift and update strobes, one per TCK, together with the current chain number.

Top module: `dbg_reg_chain`

## Requirements
- R1: After reset every register in the bank is zero, TDO is low, and the first selected scan shifts out 38 zero bits.
- R2: A frame is 38 bits shifted in this order: data bits 0 to 31, then address bits 0 to 4, then the direction bit. When the direction bit is 1, Update-DR stores the data in the addressed register. A 32-bit value such as 0x100 or 0x0 written to a watchpoint control slot reads back unchanged.
- R3: When the direction bit is 0, Update-DR leaves every register unchanged. On the next selected scan, the first 32 TDO bits are the addressed register's value at the time of that update, least significant bit first.
- R4: Capture-DR loads zeros into the address and direction fields, so TDO bits 32 to 37 of every selected scan are zero.
- R5: Capture and shift cycles without an Update-DR never change any register.
- R6: While the chain-select input is not 2, capture, shift and update have no effect on the registers or on the chain contents, and TDO stays low.
- R7: An address of 8 or more (NUM_REGS by default) names no register. A write to it changes nothing, and a read of it returns zero on the next scan.
- R8: A write frame does not change the held read result. A read followed by a write to the same address still returns the value from before the write on the scan after the write.
- R9: A scan longer than 38 bits acts as a shift line. Each TDI bit reappears on TDO 38 shifts later, and Update-DR decodes the last 38 bits shifted in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock; one edge per TAP step |
| rstN | input | 1 | Asynchronous active-low reset |
| chainSel | input | 4 | Scan chain currently selected; this chain answers to 2 |
| tapCapture | input | 1 | TAP is in Capture-DR this cycle |
| tapShift | input | 1 | TAP is in Shift-DR this cycle |
| tapUpdate | input | 1 | TAP is in Update-DR this cycle |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, bit 0 of the chain while selected |
| regBank | output | 256 | Contents of all debug registers, register i in bits 32*i+31:32*i |

## Verification
The checker assumes that the TAP never asserts more than one of capture, shift or update in the same cycle, and it flags any cycle where that is broken. The bench drives these strobes only from its scan task, which raises one strobe per clock in capture, shift, update order. It changes chain-select only between scans. Random frames draw addresses from 0 to 15, so implemented and unimplemented registers are both hit under the same one-strobe discipline.

// File: rtl/dbg_chain_pkg.sv
package dbg_chain_pkg;

  // Strobes passed from the control decode to the datapath
  typedef struct packed {
    logic active;   // chain currently selected
    logic capture;  // load held read value into the chain
    logic shift;    // move chain one bit toward TDO
    logic write;    // commit data field to addressed register
    logic read;     // latch addressed register for next capture
  } chainStrobes_t;

endpackage

// File: rtl/dbg_chain_ctrl.sv
module dbg_chain_ctrl
  import dbg_chain_pkg::*;
#(
  parameter int SEL_W    = 4,
  parameter int CHAIN_ID = 2
) (
  input  logic [SEL_W-1:0] chainSel,
  input  logic             tapCapture,
  input  logic             tapShift,
  input  logic             tapUpdate,
  input  logic             rwBit,
  output chainStrobes_t    strobes
);

  logic isSelected;

  assign isSelected = (chainSel == SEL_W'(CHAIN_ID));

  always_comb begin
    strobes.active  = isSelected;
    strobes.capture = isSelected && tapCapture;
    strobes.shift   = isSelected && tapShift;
    strobes.write   = isSelected && tapUpdate && rwBit;
    strobes.read    = isSelected && tapUpdate && !rwBit;
  end

endmodule

// File: rtl/dbg_chain_dp.sv
module dbg_chain_dp
  import dbg_chain_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 5,
  parameter int NUM_REGS = 8,
  localparam int CHAIN_LEN = DATA_W + ADDR_W + 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  chainStrobes_t              strobes,
  input  logic                       tdi,
  output logic                       tdo,
  output logic                       rwBit,
  output logic [CHAIN_LEN-1:0]       chainBits,
  output logic [NUM_REGS*DATA_W-1:0] regBank
);

  logic [CHAIN_LEN-1:0]               shiftReg;
  logic [DATA_W-1:0]                  heldRead;
  logic [NUM_REGS-1:0][DATA_W-1:0]    bank;
  logic [NUM_REGS-1:0]                hitVec;
  logic [DATA_W-1:0]                  readVal;
  logic [DATA_W-1:0]                  fieldData;
  logic [ADDR_W-1:0]                  fieldAddr;

  assign fieldData = shiftReg[DATA_W-1:0];
  assign fieldAddr = shiftReg[DATA_W +: ADDR_W];
  assign rwBit     = shiftReg[CHAIN_LEN-1];
  assign chainBits = shiftReg;
  assign tdo       = strobes.active ? shiftReg[0] : 1'b0;

  // One address comparator per implemented register
  for (genvar g = 0; g < NUM_REGS; g++) begin : gAddrDec
    assign hitVec[g] = (fieldAddr == ADDR_W'(g));
    assign regBank[g*DATA_W +: DATA_W] = bank[g];
  end

  // Unmatched addresses fall through to zero
  always_comb begin
    readVal = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (hitVec[i]) readVal = bank[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobes.capture) begin
      shiftReg <= {{(ADDR_W + 1){1'b0}}, heldRead};
    end else if (strobes.shift) begin
      shiftReg <= {tdi, shiftReg[CHAIN_LEN-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldRead <= '0;
    end else if (strobes.read) begin
      heldRead <= readVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bank <= '0;
    end else if (strobes.write) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (hitVec[i]) bank[i] <= fieldData;
      end
    end
  end

endmodule

// File: rtl/dbg_reg_chain.sv
module dbg_reg_chain
  import dbg_chain_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 5,
  parameter int NUM_REGS = 8,
  parameter int SEL_W    = 4,
  parameter int CHAIN_ID = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [SEL_W-1:0]           chainSel,
  input  logic                       tapCapture,
  input  logic                       tapShift,
  input  logic                       tapUpdate,
  input  logic                       tdi,
  output logic                       tdo,
  output logic [NUM_REGS*DATA_W-1:0] regBank
);

  localparam int CHAIN_LEN = DATA_W + ADDR_W + 1;

  chainStrobes_t        strobes;
  logic                 rwBit;
  logic [CHAIN_LEN-1:0] chainBits;

  dbg_chain_ctrl #(
    .SEL_W    (SEL_W),
    .CHAIN_ID (CHAIN_ID)
  ) u_ctrl (
    .chainSel   (chainSel),
    .tapCapture (tapCapture),
    .tapShift   (tapShift),
    .tapUpdate  (tapUpdate),
    .rwBit      (rwBit),
    .strobes    (strobes)
  );

  dbg_chain_dp #(
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .NUM_REGS (NUM_REGS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .tdi       (tdi),
    .tdo       (tdo),
    .rwBit     (rwBit),
    .chainBits (chainBits),
    .regBank   (regBank)
  );

endmodule

// File: rtl/dbg_chain_chk.sv
module dbg_chain_chk #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 5,
  parameter int NUM_REGS = 8,
  parameter int SEL_W    = 4,
  parameter int CHAIN_ID = 2,
  localparam int CHAIN_LEN = DATA_W + ADDR_W + 1
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [SEL_W-1:0]           chainSel,
  input logic                       tapCapture,
  input logic                       tapShift,
  input logic                       tapUpdate,
  input logic [CHAIN_LEN-1:0]       chainBits,
  input logic [NUM_REGS*DATA_W-1:0] regBank
);

  logic selNow;
  logic unimplAddr;

  assign selNow     = (chainSel == SEL_W'(CHAIN_ID));
  assign unimplAddr = int'(chainBits[DATA_W +: ADDR_W]) >= NUM_REGS;

  AST_ONE_TAP_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({tapCapture, tapShift, tapUpdate})); // R2

  AST_NO_UPDATE_KEEPS_BANK: assert property (@(posedge clk) disable iff (!rstN)
    !(tapUpdate && selNow) |=> $stable(regBank)); // R5

  AST_READ_KEEPS_BANK: assert property (@(posedge clk) disable iff (!rstN)
    (tapUpdate && selNow && !chainBits[CHAIN_LEN-1]) |=> $stable(regBank)); // R3

  AST_UNSELECTED_CHAIN_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !selNow |=> $stable(chainBits) && $stable(regBank)); // R6

  AST_CAPTURE_ZERO_CTRL: assert property (@(posedge clk) disable iff (!rstN)
    (tapCapture && selNow) |=> (chainBits[CHAIN_LEN-1:DATA_W] == '0)); // R4

  AST_SHIFT_ONE_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (tapShift && selNow) |=> (chainBits[CHAIN_LEN-2:0] == $past(chainBits[CHAIN_LEN-1:1]))); // R9

  AST_UNIMPL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (tapUpdate && selNow && chainBits[CHAIN_LEN-1] && unimplAddr) |=> $stable(regBank)); // R7

endmodule

bind dbg_reg_chain dbg_chain_chk #(
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .NUM_REGS (NUM_REGS),
  .SEL_W    (SEL_W),
  .CHAIN_ID (CHAIN_ID)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .chainSel   (chainSel),
  .tapCapture (tapCapture),
  .tapShift   (tapShift),
  .tapUpdate  (tapUpdate),
  .chainBits  (chainBits),
  .regBank    (regBank)
);

// File: tb/sim_dbg_reg_chain.sv
module sim_dbg_reg_chain;

  localparam int NREG = 8;
  localparam int FLEN = 38;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [3:0]       chainSel = 4'd2;
  logic             tapCapture = 1'b0;
  logic             tapShift = 1'b0;
  logic             tapUpdate = 1'b0;
  logic             tdi = 1'b0;
  logic             tdo;
  logic [NREG*32-1:0] regBank;

  int checks = 0;
  int fails  = 0;

  logic [31:0] model [NREG];
  logic [31:0] heldM;

  always #5 clk = ~clk;

  dbg_reg_chain u0 (
    .clk(clk), .rstN(rstN), .chainSel(chainSel),
    .tapCapture(tapCapture), .tapShift(tapShift), .tapUpdate(tapUpdate),
    .tdi(tdi), .tdo(tdo), .regBank(regBank)
  );

  function automatic logic [NREG*32-1:0] bankExp();
    logic [NREG*32-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*32 +: 32] = model[i];
    return v;
  endfunction

  function automatic logic [63:0] frame(logic [31:0] d, logic [4:0] a, logic rw);
    return {26'd0, rw, a, d};
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Capture, n shift cycles, optional update; TDO sampled before each shift edge
  task automatic scanBits(input logic [63:0] din, input int n, input bit doUpd, output logic [63:0] dout);
    dout = '0;
    @(negedge clk); tapCapture = 1'b1;
    @(negedge clk); tapCapture = 1'b0;
    for (int i = 0; i < n; i++) begin
      tapShift = 1'b1; tdi = din[i];
      #1 dout[i] = tdo;
      @(negedge clk);
    end
    tapShift = 1'b0; tdi = 1'b0;
    if (doUpd) begin
      tapUpdate = 1'b1;
      @(negedge clk);
      tapUpdate = 1'b0;
    end
    #1;
  endtask

  task automatic applyModel(input logic [63:0] f);
    int a;
    a = int'(f[36:32]);
    if (f[37]) begin
      if (a < NREG) model[a] = f[31:0];
    end else begin
      heldM = (a < NREG) ? model[a] : 32'd0;
    end
  endtask

  task automatic doScan(input logic [31:0] d, input logic [4:0] a, input logic rw, input string tag);
    logic [63:0] f, dout;
    string bankTag;
    f = frame(d, a, rw);
    scanBits(f, FLEN, 1'b1, dout);
    check(dout[31:0] == heldM, tag, 256'(dout[31:0]), 256'(heldM));
    check(dout[37:32] == 6'd0, "R4", 256'(dout[37:32]), 256'd0);
    applyModel(f);
    bankTag = (int'(a) >= NREG) ? "R7" : (rw ? "R2" : "R3");
    check(regBank == bankExp(), bankTag, regBank, bankExp());
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] dout, din;
    for (int i = 0; i < NREG; i++) model[i] = 32'd0;
    heldM = 32'd0;
    void'($urandom(32'h5EED_0042));

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(regBank == '0, "R1", regBank, 256'd0);
    check(tdo == 1'b0, "R1", 256'(tdo), 256'd0);

    // First scan returns all zeros; writes watchpoint control enable
    doScan(32'h0000_0100, 5'd4, 1'b1, "R1");
    // Status-like word with bits 0 and 3 set, then read it back
    doScan(32'h0000_0009, 5'd2, 1'b1, "R2");
    doScan(32'h0, 5'd2, 1'b0, "R3");
    doScan(32'h0, 5'd4, 1'b0, "R3");    // returns 0x9
    doScan(32'h0, 5'd4, 1'b1, "R3");    // returns 0x100, disables slot 4
    doScan(32'h0, 5'd4, 1'b0, "R2");
    doScan(32'hFFFF_FFFF, 5'd7, 1'b1, "R2");  // returns 0 from slot 4

    // Unimplemented addresses
    doScan(32'hDEAD_BEEF, 5'd8, 1'b1, "R7");
    doScan(32'h1234_5678, 5'd31, 1'b1, "R7");
    doScan(32'h0, 5'd9, 1'b0, "R7");
    doScan(32'h0, 5'd0, 1'b0, "R7");    // returns 0 for address 9

    // Read then write same address: held value is pre-write
    doScan(32'hA5A5_0001, 5'd1, 1'b1, "R2");
    doScan(32'h0, 5'd1, 1'b0, "R8");
    doScan(32'h5A5A_0002, 5'd1, 1'b1, "R8");
    doScan(32'h0, 5'd3, 1'b0, "R8");    // still returns 0xA5A50001

    // Shift without update
    scanBits(frame(32'hCAFE_F00D, 5'd3, 1'b1), FLEN, 1'b0, dout);
    check(regBank == bankExp(), "R5", regBank, bankExp());
    check(dout[31:0] == heldM, "R5", 256'(dout[31:0]), 256'(heldM));

    // Chain not selected
    chainSel = 4'd1;
    scanBits(frame(32'h0BAD_0BAD, 5'd0, 1'b1), FLEN, 1'b1, dout);
    check(regBank == bankExp(), "R6", regBank, bankExp());
    check(dout == 64'd0, "R6", 256'(dout), 256'd0);
    chainSel = 4'd2;
    doScan(32'h0, 5'd5, 1'b0, "R6");    // held value survived

    // Over-long scan acting as a shift line
    din = {frame(32'h7777_1111, 5'd5, 1'b1)[37:0], 8'hB4} ;
    scanBits(din, FLEN + 8, 1'b1, dout);
    check(dout[37:0] == {6'd0, heldM}, "R9", 256'(dout[37:0]), 256'({6'd0, heldM}));
    check(dout[45:38] == 8'hB4, "R9", 256'(dout[45:38]), 256'hB4);
    applyModel(din[45:8]);
    check(regBank == bankExp(), "R9", regBank, bankExp());

    // Random frames across implemented and unimplemented addresses
    for (int k = 0; k < 60; k++) begin
      logic [31:0] rd;
      logic [4:0]  ra;
      logic        rr;
      rd = $urandom;
      ra = 5'($urandom % 16);
      rr = 1'($urandom % 2);
      doScan(rd, ra, rr, rr ? "R2" : "R3");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule